// File: doc/BRIEF.md
# Multi-Mode Byte Multiplier

This block multiplies two byte-wide register operands for a small RISC core. A 3-bit mode code selects the sign treatment of the operands and whether the result is an integer product or a fractional one in 1.7 format. A fractional product is the integer product moved one place to the left. The 16-bit result leaves the block as two bytes. The high byte is meant for the odd register of a fixed pair and the low byte for the even register. Zero and carry flags come with the result.

A one-cycle start pulse launches an operation. The operands and the mode are captured on that edge. The product, the flags and a one-cycle done pulse appear on the next edge, so an operation occupies two clock cycles. While an operation is in flight the block reports busy and ignores any start. The result and flag outputs keep their values until the next operation completes.

Top module: `mulmm_top`

## Requirements
- R1: Mode code bits [1:0] = 00 treats both operands as unsigned. The 16-bit result is opa*opb.
- R2: Mode code bits [1:0] = 01 treats both operands as two's complement. The result is the 16-bit two's complement product.
- R3: Mode code bits [1:0] = 10 treats opa as two's complement and opb as unsigned. The result is the 16-bit two's complement product.
- R4: Mode code bit 2 = 1 selects fractional mode. The result is the integer product of the same sign mode shifted left by one bit, with the top bit dropped. There is no saturation, so 0x80 times 0x80 in signed fractional mode gives 0x8000.
- R5: res_hi carries result bits 15..8 and res_lo carries bits 7..0.
- R6: flag_z is 1 exactly when the full 16-bit result, after any shift, is zero.
- R7: flag_c equals bit 15 of the product before the fractional shift. In integer modes it therefore equals res_hi bit 7.
- R8: A start sampled while busy is low captures the operands and mode. On the next edge busy goes high for one cycle. On the edge after that, done pulses high for one cycle and the new result and flags appear on the outputs.
- R9: A start sampled while busy is high is ignored. It causes no extra done pulse and has no effect on the result.
- R10: Outside the done cycle, res_hi, res_lo, flag_z and flag_c keep their last values.
- R11: The reserved sign code bits [1:0] = 11 behaves as unsigned, in both the integer and the fractional variant.
- R12: While reset is high, busy, done, both result bytes and both flags are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation launch |
| mode | input | 3 | Bit 2 selects fractional; bits 1:0 select the sign treatment |
| opa | input | W | First operand (signed in the signed and mixed codes) |
| opb | input | W | Second operand (signed only in the signed code) |
| busy | output | 1 | High while an operation is in flight |
| done | output | 1 | One-cycle pulse when the result is written |
| res_hi | output | W | Result high byte (odd register) |
| res_lo | output | W | Result low byte (even register) |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The bench builds the block at the default operand width W = 8. At that width the extreme operands 0x80 and 0xFF can be hand-checked in every sign mode. These cases cover the -1.0 times -1.0 wrap, a carry that differs from result bit 15 in fractional mode, and the mixed mode treating its two operands differently. A behavioural model compares every output on every clock. It is driven with back-to-back and colliding start pulses, so the rule that a start is ignored while busy is tested alongside the arithmetic.

// File: rtl/mulmm_pkg.sv
package mulmm_pkg;
  typedef enum logic [1:0] {
    SGN_UU  = 2'b00,
    SGN_SS  = 2'b01,
    SGN_SU  = 2'b10,
    SGN_RSV = 2'b11
  } sgn_sel_e;

  typedef struct packed {
    logic     frac;
    sgn_sel_e sel;
  } mode_t;

  // Whether an operand slot is sign extended under a given sign code
  function automatic logic opnd_is_signed(sgn_sel_e sel, logic first_slot);
    logic r;
    case (sel)
      SGN_SS:  r = 1'b1;
      SGN_SU:  r = first_slot;
      default: r = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mulmm_extend.sv
module mulmm_extend
  import mulmm_pkg::*;
#(
  parameter int W = 8,
  parameter bit FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  sgn_sel_e     sel,
  input  logic [W-1:0] opnd,
  output logic [W:0]   ext_q
);
  logic ext_bit;

  always_comb ext_bit = opnd_is_signed(sel, FIRST) & opnd[W-1];

  always_ff @(posedge clk) begin
    if (rst)       ext_q <= '0;
    else if (load) ext_q <= {ext_bit, opnd};
  end
endmodule

// File: rtl/mulmm_core.sv
module mulmm_core #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           go,
  input  logic           frac,
  input  logic [W:0]     ext_a,
  input  logic [W:0]     ext_b,
  output logic [2*W-1:0] res_q,
  output logic           z_q,
  output logic           c_q,
  output logic           done_q
);
  localparam int PW = 2 * W + 2;
  localparam int RW = 2 * W;

  logic signed [PW-1:0] wide_a, wide_b, full;
  logic [RW-1:0] raw, shaped;

  always_comb begin
    wide_a = {{(W + 1){ext_a[W]}}, ext_a};
    wide_b = {{(W + 1){ext_b[W]}}, ext_b};
    full   = wide_a * wide_b;
    raw    = full[RW-1:0];
    shaped = frac ? {raw[RW-2:0], 1'b0} : raw;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      z_q    <= 1'b0;
      c_q    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= go;
      if (go) begin
        res_q <= shaped;
        z_q   <= (shaped == '0);
        c_q   <= raw[RW-1];
      end
    end
  end
endmodule

// File: rtl/mulmm_top.sv
module mulmm_top
  import mulmm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [2:0]   mode,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] res_hi,
  output logic [W-1:0] res_lo,
  output logic         flag_z,
  output logic         flag_c
);
  localparam int NOPND = 2;

  mode_t          mode_in;
  logic           accept;
  logic           frac_q;
  logic [W-1:0]   opnd_in [NOPND];
  logic [W:0]     ext_q   [NOPND];
  logic [2*W-1:0] res_q;

  always_comb begin
    mode_in    = mode_t'(mode);
    accept     = start & ~busy;
    opnd_in[0] = opa;
    opnd_in[1] = opb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      frac_q <= 1'b0;
    end else begin
      busy <= accept;
      if (accept) frac_q <= mode_in.frac;
    end
  end

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    mulmm_extend #(.W(W), .FIRST(g == 0)) u_ext (
      .clk  (clk),
      .rst  (rst),
      .load (accept),
      .sel  (mode_in.sel),
      .opnd (opnd_in[g]),
      .ext_q(ext_q[g])
    );
  end

  mulmm_core #(.W(W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .go    (busy),
    .frac  (frac_q),
    .ext_a (ext_q[0]),
    .ext_b (ext_q[1]),
    .res_q (res_q),
    .z_q   (flag_z),
    .c_q   (flag_c),
    .done_q(done)
  );

  always_comb begin
    res_hi = res_q[2*W-1:W];
    res_lo = res_q[W-1:0];
  end
endmodule

// File: rtl/mulmm_chk.sv
module mulmm_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic [2:0]   mode,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] res_hi,
  input logic [W-1:0] res_lo,
  input logic         flag_z,
  input logic         flag_c
);
  logic frac_seen;

  always_ff @(posedge clk) begin
    if (rst)                frac_seen <= 1'b0;
    else if (start && !busy) frac_seen <= mode[2];
  end

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  assert_busy_done_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy));

  assert_done_source_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> (flag_z == ({res_hi, res_lo} == '0)));

  assert_frac_lsb_R4: assert property (@(posedge clk) disable iff (rst)
    (done && frac_seen) |-> !res_lo[0]);

  assert_int_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (done && !frac_seen) |-> (flag_c == res_hi[W-1]));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({res_hi, res_lo, flag_z, flag_c}));
endmodule

bind mulmm_top mulmm_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mode(mode), .busy(busy), .done(done),
  .res_hi(res_hi), .res_lo(res_lo), .flag_z(flag_z), .flag_c(flag_c)
);

// File: tb/sim_mulmm_top.sv
`timescale 1ns/1ps
module sim_mulmm_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] mode = 3'b000;
  logic [7:0] opa = 8'h00, opb = 8'h00;
  logic       busy, done, flag_z, flag_c;
  logic [7:0] res_hi, res_lo;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mulmm_top #(.W(8)) u0 (
    .clk(clk), .rst(rst), .start(start), .mode(mode), .opa(opa), .opb(opb),
    .busy(busy), .done(done), .res_hi(res_hi), .res_lo(res_lo),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  // Behavioural reference model
  bit          m_busy = 0, m_done = 0, m_z = 0, m_c = 0;
  int          m_a, m_b;
  int          m_mode;
  logic [15:0] m_res = 16'h0;

  function automatic logic [16:0] ref_calc(int a, int b, int md);
    int sa, sb, p;
    logic [15:0] raw, r;
    int sel;
    sel = md & 3;
    sa = a; sb = b;
    if ((sel == 1 || sel == 2) && a >= 128) sa = a - 256;
    if (sel == 1 && b >= 128) sb = b - 256;
    p = sa * sb;
    raw = p[15:0];
    r = (md >= 4) ? {raw[14:0], 1'b0} : raw;
    return {raw[15], r};
  endfunction

  always @(posedge clk) begin
    logic [16:0] cr;
    if (rst) begin
      m_busy = 0; m_done = 0; m_res = 0; m_z = 0; m_c = 0;
    end else if (m_busy) begin
      cr = ref_calc(m_a, m_b, m_mode);
      m_res = cr[15:0]; m_c = cr[16]; m_z = (cr[15:0] == 16'h0);
      m_done = 1; m_busy = 0;
    end else begin
      m_done = 0;
      if (start) begin
        m_a = opa; m_b = opb; m_mode = mode; m_busy = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Per-clock comparison with the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(busy == m_busy, "R8 busy vs model", busy, m_busy);
      chk(done == m_done, "R8 done vs model", done, m_done);
      chk({res_hi, res_lo} == m_res, "R5 result vs model", {res_hi, res_lo}, m_res);
      chk({flag_z, flag_c} == {m_z, m_c}, "R6 R7 flags vs model", {flag_z, flag_c}, {m_z, m_c});
    end
  end

  task automatic op(input logic [7:0] x, input logic [7:0] y, input logic [2:0] md,
                    input logic [15:0] er, input bit ez, input bit ec, input string tag);
    @(negedge clk);
    start = 1; opa = x; opb = y; mode = md;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, {tag, " R8 busy after start"}, busy, 1);
    @(negedge clk);
    chk(done == 1'b1, {tag, " R8 done"}, done, 1);
    chk({res_hi, res_lo} == er, {tag, " result"}, {res_hi, res_lo}, er);
    chk(flag_z == ez, {tag, " R6 zero flag"}, flag_z, ez);
    chk(flag_c == ec, {tag, " R7 carry flag"}, flag_c, ec);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({busy, done, res_hi, res_lo, flag_z, flag_c} == 20'h0, "R12 reset state",
        {busy, done, res_hi, res_lo, flag_z, flag_c}, 0);
    rst = 0;

    op(8'hFF, 8'hFF, 3'b000, 16'hFE01, 0, 1, "R1 unsigned max");
    op(8'h00, 8'h37, 3'b000, 16'h0000, 1, 0, "R6 zero product");
    op(8'h80, 8'h80, 3'b001, 16'h4000, 0, 0, "R2 signed min*min");
    op(8'hFF, 8'h01, 3'b001, 16'hFFFF, 0, 1, "R2 signed -1*1");
    op(8'hFF, 8'h02, 3'b010, 16'hFFFE, 0, 1, "R3 mixed -1*2");
    op(8'h02, 8'hFF, 3'b010, 16'h01FE, 0, 0, "R3 mixed 2*255");
    op(8'h80, 8'h80, 3'b101, 16'h8000, 0, 0, "R4 frac signed wrap");
    op(8'h80, 8'h80, 3'b100, 16'h8000, 0, 0, "R7 frac carry pre-shift");
    op(8'hFF, 8'hFF, 3'b100, 16'hFC02, 0, 1, "R4 frac unsigned");
    op(8'hFF, 8'h02, 3'b110, 16'hFFFC, 0, 1, "R4 frac mixed");
    op(8'hFF, 8'hFF, 3'b011, 16'hFE01, 0, 1, "R11 reserved integer");
    op(8'hFF, 8'hFF, 3'b111, 16'hFC02, 0, 1, "R11 reserved frac");

    // R9: second start while busy is ignored
    @(negedge clk);
    start = 1; opa = 8'h03; opb = 8'h05; mode = 3'b000;
    @(negedge clk);
    opa = 8'h07; opb = 8'h09;
    @(negedge clk);
    start = 0;
    chk(done == 1'b1, "R9 first op done", done, 1);
    chk({res_hi, res_lo} == 16'h000F, "R9 busy start ignored", {res_hi, res_lo}, 16'h000F);
    @(negedge clk);
    chk(done == 1'b0, "R9 no extra done", done, 0);
    // R10: outputs hold
    repeat (3) @(negedge clk);
    chk({res_hi, res_lo} == 16'h000F, "R10 result held", {res_hi, res_lo}, 16'h000F);

    // Random traffic compared against the model every clock
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      start = ($urandom_range(0, 2) != 0);
      opa = 8'($urandom); opb = 8'($urandom); mode = 3'($urandom);
    end
    @(negedge clk);
    start = 0;
    repeat (4) @(negedge clk);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule